// File: doc/BRIEF.md
# Counter Overflow Flag Unit

This block holds sticky overflow flags for a set of hardware counters: one 64-bit cycle counter and up to 31 event counters. Each counter hands in an increment pulse together with its value before that increment. The block flags an unsigned wrap at either 32 or 64 bits; one mode input covers the cycle counter and another covers all the event counters.

The flags can be read through one 32-bit status word on a simple single-cycle register bus. On that bus, writing a 1 to a bit sets the flag and writing a 0 does nothing. An access gate looks at the power state, the lock inputs and the external-access permission. From these it grants read-write access, grants read-only access, or returns an error. A separate clear-mask port lets the counter logic next to this block clear flags.

Top module: `ovf_status_unit`

## Requirements
- R1: After reset every flag is 0, and `rd_data` and `rd_err` are 0.
- R2: With `cyc_long` at 0, an increment pulse on the cycle counter while bits 31..0 of `cyc_val` are all ones sets status bit 31 on the next clock edge. This applies whatever the upper 32 bits hold.
- R3: With `cyc_long` at 1, status bit 31 is set only when all 64 bits of `cyc_val` are ones at the increment. A wrap of the low 32 bits alone does not set it.
- R4: Event counter i sets status bit i. The counter's value sits at bits 64*i+63..64*i of `evt_val`. The wrap width is 32 bits when `evt_long` is 0 and 64 bits when it is 1.
- R5: A value of all ones with no increment pulse sets no flag.
- R6: A granted read-write access with `we` at 1 ORs `wdata` into the flags. Bits of `wdata` that are 0 leave their flags unchanged.
- R7: Status bits 30 down to NUM_EVT always read 0, and writes to them are ignored.
- R8: When access is allowed and `sw_lock` is 1, reads return the flags, writes change nothing, and `rd_err` stays 0.
- R9: An access to the status offset gets `rd_err` = 1 and `rd_data` = 0, and changes no flag, if any of the following holds: `core_pwr` is 0, `dbl_lock` is 1, `os_lock` is 1, or `ext_allow` is 0.
- R10: An access to any offset other than 0xCC0 returns 0, raises no error and changes no flag.
- R11: A bit set in `clr` clears that flag. An overflow or a granted write-one to the same bit in the same cycle wins, and the flag ends at 1.
- R12: A set flag stays set until its bit is cleared.
- R13: `rd_data` and `rd_err` are registered. They answer the request of the previous cycle, and `rd_data` shows the flags as they stood before that cycle's update. Both are 0 after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_inc | input | 1 | Cycle counter increment pulse |
| cyc_val | input | 64 | Cycle counter value before the increment |
| cyc_long | input | 1 | 1: cycle counter wraps at 64 bits, 0: wraps at 32 bits |
| evt_inc | input | NUM_EVT | Event counter increment pulses |
| evt_val | input | 64*NUM_EVT | Event counter values before the increment, counter i at bits 64*i+63..64*i |
| evt_long | input | 1 | 1: event counters wrap at 64 bits, 0: wrap at 32 bits |
| clr | input | 32 | Clear mask for the flags |
| req | input | 1 | Bus access request |
| addr | input | 12 | Byte offset in the register window |
| we | input | 1 | 1 for a write access |
| wdata | input | 32 | Write data, where a 1 sets a flag |
| core_pwr | input | 1 | Core is powered |
| dbl_lock | input | 1 | Double lock is set |
| os_lock | input | 1 | OS lock is set |
| ext_allow | input | 1 | External access to the counters is permitted |
| sw_lock | input | 1 | Software lock is set, which makes access read-only |
| rd_data | output | 32 | Read data, one cycle after the request |
| rd_err | output | 1 | Error response, one cycle after the request |

## Verification
The overflow detectors are tested with three kinds of counter value: all 64 bits set, only the low 32 bits set, and random values. Each kind is tried in both width modes, so the tests can show whether a detector compares the right number of bits. Flag updates are tested with increments, clears and write-ones landing on the same bit in the same cycle, which separates the correct set-wins priority from a clear-wins one. Random combinations of the gate inputs and offsets, with sparse write data, tell apart the three access outcomes and the decode of foreign offsets.

// File: rtl/ovf_pkg.sv
// Shared types and constants for the counter overflow flag unit.
// Assumes a 32-bit status word with the cycle counter flag at the top bit.
package ovf_pkg;
    localparam int unsigned STATUS_W = 32;
    localparam int unsigned CNT_W    = 64;
    localparam int unsigned CYC_BIT  = 31;

    // Outcome of the bus access gate.
    typedef enum logic [1:0] {
        ACC_DENY = 2'd0,
        ACC_RO   = 2'd1,
        ACC_RW   = 2'd2
    } acc_mode_e;
endpackage

// File: rtl/ovf_detect.sv
// Wrap detector for one counter. It takes the counter value before the
// increment and reports an unsigned carry out of the chosen width.
// Assumes the counter advances by exactly one for each increment pulse.
module ovf_detect #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             inc,
    input  logic [WIDTH-1:0] val,
    input  logic             long_mode,
    output logic             ovf
);
    localparam int unsigned HALF = WIDTH / 2;

    // A carry leaves the selected width only when every bit of that width is set.
    always_comb begin
        if (long_mode) ovf = inc & (&val);
        else           ovf = inc & (&val[HALF-1:0]);
    end
endmodule

// File: rtl/ovf_access_gate.sv
// Bus access gate. It combines the power, lock and permission inputs into
// deny, read-only or read-write. Assumes all inputs are steady in the access cycle.
module ovf_access_gate
    import ovf_pkg::*;
(
    input  logic      core_pwr,
    input  logic      dbl_lock,
    input  logic      os_lock,
    input  logic      ext_allow,
    input  logic      sw_lock,
    output acc_mode_e mode
);
    logic open_path;

    // Access is possible only with power on, both locks clear and permission given.
    always_comb begin
        open_path = core_pwr & ~dbl_lock & ~os_lock & ext_allow;
        if (!open_path)   mode = ACC_DENY;
        else if (sw_lock) mode = ACC_RO;
        else              mode = ACC_RW;
    end
endmodule

// File: rtl/ovf_flag_bank.sv
// Sticky flag register. Clears act only on the previous value, so a set from
// an overflow or a write in the same cycle wins. Bits with no counter behind
// them stay 0.
module ovf_flag_bank
    import ovf_pkg::*;
#(
    parameter int unsigned NUM_EVT = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] ovf_in,
    input  logic [STATUS_W-1:0] set_in,
    input  logic [STATUS_W-1:0] clr_in,
    output logic [STATUS_W-1:0] flags
);
    localparam logic [STATUS_W-1:0] IMPL_MASK =
        (STATUS_W'(1) << CYC_BIT) | ((STATUS_W'(1) << NUM_EVT) - STATUS_W'(1));

    logic [STATUS_W-1:0] flags_d;

    // Next state: keep the bits not cleared, then add every new set.
    always_comb flags_d = ((flags & ~clr_in) | ovf_in | set_in) & IMPL_MASK;

    // Flag storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_d;
    end
endmodule

// File: rtl/ovf_status_unit.sv
// Top of the counter overflow flag unit. It wraps the per-counter detectors,
// the access gate and the flag bank, and answers bus accesses one cycle late.
// Assumes 1 <= NUM_EVT <= 31 and a single-cycle request bus.
module ovf_status_unit
    import ovf_pkg::*;
#(
    parameter int unsigned NUM_EVT    = 6,
    parameter int unsigned ADDR_W     = 12,
    parameter logic [11:0] STATUS_OFS = 12'hCC0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cyc_inc,
    input  logic [63:0]            cyc_val,
    input  logic                   cyc_long,
    input  logic [NUM_EVT-1:0]     evt_inc,
    input  logic [64*NUM_EVT-1:0]  evt_val,
    input  logic                   evt_long,
    input  logic [31:0]            clr,
    input  logic                   req,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   we,
    input  logic [31:0]            wdata,
    input  logic                   core_pwr,
    input  logic                   dbl_lock,
    input  logic                   os_lock,
    input  logic                   ext_allow,
    input  logic                   sw_lock,
    output logic [31:0]            rd_data,
    output logic                   rd_err
);
    localparam int unsigned SPARE = STATUS_W - 1 - NUM_EVT;

    logic [STATUS_W-1:0] ovf_vec;
    logic [STATUS_W-1:0] set_vec;
    logic [STATUS_W-1:0] flag_q;
    logic                cyc_ovf;
    logic [NUM_EVT-1:0]  evt_ovf;
    acc_mode_e           mode;
    logic                hit;

    ovf_detect #(.WIDTH(CNT_W)) i_cyc_det (
        .inc(cyc_inc), .val(cyc_val), .long_mode(cyc_long), .ovf(cyc_ovf)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        ovf_detect #(.WIDTH(CNT_W)) i_evt_det (
            .inc(evt_inc[g]), .val(evt_val[CNT_W*g +: CNT_W]),
            .long_mode(evt_long), .ovf(evt_ovf[g])
        );
    end

    // Gather the overflow pulses into status-word order.
    if (SPARE > 0) begin : g_spare
        always_comb ovf_vec = {cyc_ovf, {SPARE{1'b0}}, evt_ovf};
    end else begin : g_full
        always_comb ovf_vec = {cyc_ovf, evt_ovf};
    end

    ovf_access_gate i_gate (
        .core_pwr(core_pwr), .dbl_lock(dbl_lock), .os_lock(os_lock),
        .ext_allow(ext_allow), .sw_lock(sw_lock), .mode(mode)
    );

    // Address decode and the write-one-to-set mask.
    always_comb begin
        hit     = req && (addr == STATUS_OFS[ADDR_W-1:0]);
        set_vec = (hit && we && mode == ACC_RW) ? wdata : '0;
    end

    ovf_flag_bank #(.NUM_EVT(NUM_EVT)) i_bank (
        .clk(clk), .rst_n(rst_n), .ovf_in(ovf_vec), .set_in(set_vec),
        .clr_in(clr), .flags(flag_q)
    );

    // Registered response: flags before this cycle's update, or an error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_err  <= 1'b0;
        end else begin
            rd_data <= (hit && mode != ACC_DENY) ? flag_q : '0;
            rd_err  <= hit && mode == ACC_DENY;
        end
    end
endmodule

// File: rtl/ovf_status_checker.sv
// Assertion checker for the counter overflow flag unit, bound to the top.
module ovf_status_checker #(
    parameter int unsigned NUM_EVT    = 6,
    parameter int unsigned ADDR_W     = 12,
    parameter logic [11:0] STATUS_OFS = 12'hCC0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_inc,
    input logic [63:0]       cyc_val,
    input logic [31:0]       clr,
    input logic              req,
    input logic [ADDR_W-1:0] addr,
    input logic              core_pwr,
    input logic              dbl_lock,
    input logic              os_lock,
    input logic              ext_allow,
    input logic [31:0]       flag_q,
    input logic [31:0]       rd_data,
    input logic              rd_err
);
    localparam logic [31:0] IMPL_MASK = 32'h8000_0000 | ((32'd1 << NUM_EVT) - 32'd1);

    // R9: an error response never carries data.
    p_err_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_data == 32'd0);

    // R9: a denied access to the status offset is answered with an error.
    p_denied_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && addr == STATUS_OFS[ADDR_W-1:0] &&
         !(core_pwr && !dbl_lock && !os_lock && ext_allow)) |=> rd_err);

    // R13: a response appears only after a request.
    p_resp_after_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_err || rd_data != 32'd0) |-> $past(req));

    // R7: unimplemented bits never read as 1.
    p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~IMPL_MASK) == 32'd0);

    // R12: a set flag drops only where a clear was applied.
    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (($past(flag_q) & ~$past(clr) & ~flag_q) == 32'd0));

    // R2: a full 64-bit wrap sets the cycle flag in either mode.
    p_cyc_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_inc && (&cyc_val)) |=> flag_q[31]);
endmodule

bind ovf_status_unit ovf_status_checker #(
    .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cyc_inc(cyc_inc), .cyc_val(cyc_val),
    .clr(clr), .req(req), .addr(addr), .core_pwr(core_pwr),
    .dbl_lock(dbl_lock), .os_lock(os_lock), .ext_allow(ext_allow),
    .flag_q(flag_q), .rd_data(rd_data), .rd_err(rd_err)
);

// File: tb/test_ovf_status_unit.sv
// Bench for the counter overflow flag unit: directed corner cases, then
// seeded random traffic, checked against a reference model in the bench.
module test_ovf_status_unit;
    localparam int unsigned N   = 6;
    localparam logic [11:0] OFS = 12'hCC0;
    localparam logic [31:0] IMPL = 32'h8000_0000 | ((32'd1 << N) - 32'd1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_inc = 0, cyc_long = 0, evt_long = 0;
    logic [63:0] cyc_val = '0;
    logic [N-1:0] evt_inc = '0;
    logic [64*N-1:0] evt_val = '0;
    logic [31:0] clr = '0, wdata = '0;
    logic req = 0, we = 0;
    logic [11:0] addr = '0;
    logic core_pwr = 1, dbl_lock = 0, os_lock = 0, ext_allow = 1, sw_lock = 0;
    logic [31:0] rd_data;
    logic rd_err;

    int checks = 0, fails = 0;
    logic [31:0] m_flags = '0;
    bit done = 0;

    always #2ns clk = ~clk;

    ovf_status_unit #(.NUM_EVT(N)) i_ovf_status_unit (
        .clk(clk), .rst_n(rst_n), .cyc_inc(cyc_inc), .cyc_val(cyc_val),
        .cyc_long(cyc_long), .evt_inc(evt_inc), .evt_val(evt_val),
        .evt_long(evt_long), .clr(clr), .req(req), .addr(addr), .we(we),
        .wdata(wdata), .core_pwr(core_pwr), .dbl_lock(dbl_lock),
        .os_lock(os_lock), .ext_allow(ext_allow), .sw_lock(sw_lock),
        .rd_data(rd_data), .rd_err(rd_err)
    );

    function automatic logic wraps(logic inc, logic [63:0] v, logic lng);
        return inc && (lng ? (v == '1) : (v[31:0] == '1));
    endfunction

    function automatic logic gate_open();
        return core_pwr && !dbl_lock && !os_lock && ext_allow;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: model the response and next flags, then compare after the edge.
    task automatic drive(string tag);
        logic hit;
        logic [31:0] e_data, ovf, wset;
        logic e_err;
        hit    = req && addr == OFS;
        e_data = (hit && gate_open()) ? m_flags : '0;
        e_err  = hit && !gate_open();
        ovf = '0;
        ovf[31] = wraps(cyc_inc, cyc_val, cyc_long);
        for (int i = 0; i < N; i++) ovf[i] = wraps(evt_inc[i], evt_val[64*i +: 64], evt_long);
        wset = (hit && gate_open() && !sw_lock && we) ? wdata : '0;
        m_flags = ((m_flags & ~clr) | ovf | wset) & IMPL;
        @(posedge clk);
        #1ns;
        check({tag, " rd_data"}, rd_data, e_data);
        check({tag, " rd_err"}, {31'd0, rd_err}, {31'd0, e_err});
    endtask

    task automatic quiet();
        cyc_inc = 0; evt_inc = '0; clr = '0; req = 0; we = 0; wdata = '0; addr = OFS;
        core_pwr = 1; dbl_lock = 0; os_lock = 0; ext_allow = 1; sw_lock = 0;
    endtask

    task automatic rd(string tag);
        quiet(); req = 1; drive(tag);
        quiet(); drive({tag, " idle"});
    endtask

    function automatic logic [63:0] pick_val();
        case ($urandom % 3)
            0: return '1;
            1: return {$urandom, 32'hFFFF_FFFF};
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        #400000ns;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1ns;
        check("R1 reset rd_data", rd_data, 32'd0);
        check("R1 reset rd_err", {31'd0, rd_err}, 32'd0);
        rst_n = 1;
        quiet();
        rd("R1 flags after reset");
        // R2: 32-bit cycle wrap, upper half ignored
        quiet(); cyc_inc = 1; cyc_val = 64'h0000_0005_FFFF_FFFF; drive("R2 cyc wrap32");
        rd("R2 read");
        quiet(); clr = '1; drive("R11 clear all");
        // R3: 64-bit mode needs all bits
        quiet(); cyc_long = 1; cyc_inc = 1; cyc_val = 64'h0000_0005_FFFF_FFFF; drive("R3 low only");
        rd("R3 no flag");
        quiet(); cyc_inc = 1; cyc_val = '1; drive("R3 full wrap");
        rd("R3 flag set");
        // R4: event counters per mode
        quiet(); evt_long = 0; evt_inc[2] = 1; evt_val[128 +: 64] = 64'h1234_0000_FFFF_FFFF; drive("R4 evt2 wrap32");
        quiet(); evt_long = 1; evt_inc[3] = 1; evt_val[192 +: 64] = 64'h1234_0000_FFFF_FFFF; drive("R4 evt3 no wrap64");
        rd("R4 read");
        // R5: no pulse, no flag
        quiet(); clr = '1; evt_val = '1; cyc_val = '1; drive("R5 clear");
        quiet(); drive("R5 idle all ones");
        rd("R5 read");
        // R6: write one sets, zero has no effect
        quiet(); req = 1; we = 1; wdata = 32'h1; drive("R6 write one");
        quiet(); req = 1; we = 1; wdata = 32'h0; drive("R6 write zero");
        rd("R6 read");
        // R7: spare bits
        quiet(); req = 1; we = 1; wdata = '1; drive("R7 write all");
        rd("R7 read");
        check("R7 literal", m_flags, IMPL);
        // R11: set wins over clear
        quiet(); clr = '1; evt_long = 0; evt_inc[1] = 1; evt_val[64 +: 64] = 64'hFFFF_FFFF;
        req = 1; we = 1; wdata = 32'h1; drive("R11 set beats clear");
        rd("R11 read");
        // R12: sticky through idle
        quiet(); repeat (5) drive("R12 idle");
        rd("R12 read");
        // R8 / R9 / R10 directed
        quiet(); sw_lock = 1; req = 1; we = 1; wdata = 32'h8000_0004; drive("R8 ro write");
        rd("R8 read");
        quiet(); os_lock = 1; req = 1; we = 1; wdata = 32'h8; drive("R9 os lock");
        rd("R9 read");
        quiet(); addr = 12'hCC4; req = 1; we = 1; wdata = 32'h10; drive("R10 other offset");
        rd("R10 read");
        // Random traffic
        for (int k = 0; k < 4000; k++) begin
            string tag;
            cyc_inc  = $urandom % 4 == 0;
            cyc_val  = pick_val();
            cyc_long = $urandom % 2 == 0;
            evt_long = $urandom % 2 == 0;
            evt_inc  = N'($urandom) & N'($urandom);
            for (int i = 0; i < N; i++) evt_val[64*i +: 64] = pick_val();
            clr      = ($urandom % 8 == 0) ? ($urandom & $urandom) : '0;
            req      = $urandom % 2 == 0;
            addr     = ($urandom % 5 == 0) ? 12'($urandom) : OFS;
            we       = $urandom % 2 == 0;
            wdata    = $urandom & $urandom & $urandom;
            core_pwr = $urandom % 10 != 0;
            dbl_lock = $urandom % 10 == 0;
            os_lock  = $urandom % 10 == 0;
            ext_allow = $urandom % 10 != 0;
            sw_lock  = $urandom % 4 == 0;
            if (!req)                tag = "R13 random";
            else if (addr != OFS)    tag = "R10 random";
            else if (!gate_open())   tag = "R9 random";
            else if (sw_lock)        tag = "R8 random";
            else                     tag = "R6 random";
            drive(tag);
        end
        rd("R12 final read");
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule